// File: doc/BRIEF.md
# Processor Selection Window

This register block sits inside an interrupt routing unit. Software uses it to pick one processing element by writing that element's affinity identifier into a selector register. Software can then look at the chosen element through a small window: a configuration register and a status register. Every interrupt domain keeps its own selector, and each access names the domain it is made on.

The status word is not stored. It is built on every read by comparing the selected identifier with a table of known affinity identifiers, which arrives as an input bus together with a count of live entries. Selection takes effect at once, so the status always shows that the element is idle. When the identifier is known, the status also flags it as valid and online. The participation configuration for spread-out delivery is not implemented: it reads as zero and ignores writes.

Accesses use a plain 32-bit strobe interface. Read data comes back from a register one cycle after the read strobe. An offset outside the window raises an error pulse.

Top module: `pe_sel_window`

## Requirements
- R1: A write at offset 0x00 stores all 32 bits of write data unchanged as the selector of the addressed domain. A later read at offset 0x00 returns that value.
- R2: Each of the four domains, chosen by `req_dom`, has its own selector. A write to one domain leaves the selectors of all other domains unchanged.
- R3: A read at offset 0x04 (configuration) returns zero. A write there has no effect on any register.
- R4: A read at offset 0x08 (status) always returns bit 2 (idle) set. Every bit above bit 2 is zero.
- R5: In a status read, bit 1 (valid) and bit 0 (online) are both set exactly when the domain's selector equals one of the live table entries. Otherwise both bits are clear.
- R6: After reset, the selector of every domain is zero, and `rsp_valid` and `rsp_err` are low.
- R7: `rsp_valid` is high in exactly the cycle after a read strobe, with `rsp_rdata` holding the result. In every other cycle `rsp_rdata` is zero.
- R8: An access (read or write) to any offset other than 0x00, 0x04 or 0x08 raises `rsp_err` for one cycle in the following cycle. Such a read returns zero, and such a write changes nothing.
- R9: Table entry i (bits 32*i+31 down to 32*i) is live only when i < `aff_count`. A count above 8 makes all eight entries live, and a count of zero makes none live.
- R10: A write to the status offset is ignored and does not raise `rsp_err`.
- R11: When a read and a write to the selector of the same domain arrive in the same cycle, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_dom | input | 2 | Domain index of the access |
| req_addr | input | 8 | Byte offset within the window |
| req_wdata | input | 32 | Write data |
| aff_table | input | 256 | Eight 32-bit known affinity identifiers, entry 0 in the low bits |
| aff_count | input | 4 | Number of live table entries |
| rsp_rdata | output | 32 | Registered read data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read strobe |
| rsp_err | output | 1 | Unmapped-offset pulse |

## Verification
The hardest status to reach is the one where a selector matches a table entry that lies at or beyond the live count. In that case valid and online must stay clear even though the value is in the table. A random 32-bit selector almost never equals any table entry, so the stimulus writes values copied from random table positions half of the time. It also redraws the count over the full 4-bit range, including zero and values above eight. Same-cycle read and write of one selector, and a write into one domain followed by reads of the others, are driven as directed cases.

// File: rtl/pe_sel_pkg.sv
package pe_sel_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    REG_SEL  = 2'd0,
    REG_CFG  = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/pe_sel_decode.sv
module pe_sel_decode
  import pe_sel_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_SEL  = 'h00,
  parameter logic [ADDR_W-1:0] OFF_CFG  = 'h04,
  parameter logic [ADDR_W-1:0] OFF_STAT = 'h08
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind
);
  always_comb begin
    if (addr == OFF_SEL)       kind = REG_SEL;
    else if (addr == OFF_CFG)  kind = REG_CFG;
    else if (addr == OFF_STAT) kind = REG_STAT;
    else                       kind = REG_NONE;
  end
endmodule

// File: rtl/pe_sel_bank.sv
module pe_sel_bank
  import pe_sel_pkg::*;
#(
  parameter int N_DOM = 4,
  localparam int DOM_W = (N_DOM > 1) ? $clog2(N_DOM) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DOM_W-1:0]  wr_dom,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DOM_W-1:0]  rd_dom,
  output logic [DATA_W-1:0] rd_sel
);
  logic [DATA_W-1:0] sel_q [N_DOM];

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    localparam logic [DOM_W-1:0] DID = DOM_W'(d);

    always_ff @(posedge clk) begin
      if (rst)                          sel_q[d] <= '0;
      else if (wr_en && wr_dom == DID)  sel_q[d] <= wdata;
    end

    p_dom_isolate_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_dom != DID) |=> $stable(sel_q[d]));

    p_sel_store_r1: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_dom == DID) |=> (sel_q[d] == $past(wdata)));
  end

  assign rd_sel = sel_q[rd_dom];
endmodule

// File: rtl/pe_aff_match.sv
module pe_aff_match
  import pe_sel_pkg::*;
#(
  parameter int N_AFF = 8,
  localparam int CNT_W = $clog2(N_AFF + 1)
) (
  input  logic [DATA_W-1:0]       sel,
  input  logic [N_AFF*DATA_W-1:0] table_in,
  input  logic [CNT_W-1:0]        count,
  output logic                    hit
);
  logic [N_AFF-1:0] entry_hit;

  for (genvar i = 0; i < N_AFF; i++) begin : g_ent
    localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
    assign entry_hit[i] = (count > IDX) && (table_in[i*DATA_W +: DATA_W] == sel);
  end

  assign hit = |entry_hit;

  always_comb begin
    if (count == '0) p_none_live_r9: assert (!hit);
  end
endmodule

// File: rtl/pe_sel_window.sv
module pe_sel_window
  import pe_sel_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int N_DOM = 4,
  parameter int N_AFF = 8,
  parameter logic [ADDR_W-1:0] OFF_SEL  = 'h00,
  parameter logic [ADDR_W-1:0] OFF_CFG  = 'h04,
  parameter logic [ADDR_W-1:0] OFF_STAT = 'h08,
  parameter int ONLINE_BIT = 0,
  parameter int V_BIT = 1,
  parameter int IDLE_BIT = 2,
  localparam int DOM_W = (N_DOM > 1) ? $clog2(N_DOM) : 1,
  localparam int CNT_W = $clog2(N_AFF + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_rd,
  input  logic                    req_wr,
  input  logic [DOM_W-1:0]        req_dom,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  input  logic [N_AFF*DATA_W-1:0] aff_table,
  input  logic [CNT_W-1:0]        aff_count,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic                    rsp_valid,
  output logic                    rsp_err
);
  reg_kind_e         kind;
  logic [DATA_W-1:0] cur_sel;
  logic              known;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] rd_mux;
  logic              bad_off;

  pe_sel_decode #(
    .ADDR_W(ADDR_W), .OFF_SEL(OFF_SEL), .OFF_CFG(OFF_CFG), .OFF_STAT(OFF_STAT)
  ) u_dec (
    .addr(req_addr),
    .kind(kind)
  );

  pe_sel_bank #(.N_DOM(N_DOM)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .wr_en (req_wr && kind == REG_SEL),
    .wr_dom(req_dom),
    .wdata (req_wdata),
    .rd_dom(req_dom),
    .rd_sel(cur_sel)
  );

  pe_aff_match #(.N_AFF(N_AFF)) u_match (
    .sel     (cur_sel),
    .table_in(aff_table),
    .count   (aff_count),
    .hit     (known)
  );

  always_comb begin
    stat_word = '0;
    stat_word[IDLE_BIT] = 1'b1;
    if (known) begin
      stat_word[V_BIT]      = 1'b1;
      stat_word[ONLINE_BIT] = 1'b1;
    end
  end

  always_comb begin
    unique case (kind)
      REG_SEL:  rd_mux = cur_sel;
      REG_STAT: rd_mux = stat_word;
      default:  rd_mux = '0;
    endcase
  end

  assign bad_off = (req_rd || req_wr) && kind == REG_NONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_rdata <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_rd;
      rsp_rdata <= req_rd ? rd_mux : '0;
      rsp_err   <= bad_off;
    end
  end

  p_cfg_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (req_rd && req_addr == OFF_CFG) |=> (rsp_rdata == '0));

  p_idle_set_r4: assert property (@(posedge clk) disable iff (rst)
    (req_rd && req_addr == OFF_STAT) |=> rsp_rdata[IDLE_BIT]);

  p_v_online_pair_r5: assert property (@(posedge clk) disable iff (rst)
    (req_rd && req_addr == OFF_STAT) |=> (rsp_rdata[V_BIT] == rsp_rdata[ONLINE_BIT]));

  p_valid_follows_r7: assert property (@(posedge clk) disable iff (rst)
    req_rd |=> rsp_valid);

  p_idle_data_r7: assert property (@(posedge clk) disable iff (rst)
    !req_rd |=> (!rsp_valid && rsp_rdata == '0));

  p_unmapped_err_r8: assert property (@(posedge clk) disable iff (rst)
    (req_rd && req_addr != OFF_SEL && req_addr != OFF_CFG && req_addr != OFF_STAT)
      |=> (rsp_err && rsp_rdata == '0));

  p_stat_wr_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (req_wr && !req_rd && req_addr == OFF_STAT) |=> !rsp_err);
endmodule

// File: tb/pe_sel_window_test.sv
`timescale 1ns/1ps
module pe_sel_window_test;
  localparam int N_AFF = 8;
  localparam int N_DOM = 4;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  req_rd = 1'b0;
  logic                  req_wr = 1'b0;
  logic [1:0]            req_dom = '0;
  logic [7:0]            req_addr = '0;
  logic [31:0]           req_wdata = '0;
  logic [N_AFF*32-1:0]   aff_table = '0;
  logic [3:0]            aff_count = '0;
  logic [31:0]           rsp_rdata;
  logic                  rsp_valid;
  logic                  rsp_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_sel [N_DOM];

  always #2.5 clk = ~clk;

  pe_sel_window uut (
    .clk(clk), .rst(rst), .req_rd(req_rd), .req_wr(req_wr), .req_dom(req_dom),
    .req_addr(req_addr), .req_wdata(req_wdata), .aff_table(aff_table),
    .aff_count(aff_count), .rsp_rdata(rsp_rdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err)
  );

  function automatic bit is_known(input logic [31:0] v);
    int lim = (aff_count > 4'd8) ? 8 : int'(aff_count);
    for (int i = 0; i < lim; i++)
      if (aff_table[i*32 +: 32] == v) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_read(input logic [1:0] d, input logic [7:0] a);
    if (a == 8'h00) return exp_sel[d];
    if (a == 8'h08) return is_known(exp_sel[d]) ? 32'h7 : 32'h4;
    return 32'h0;
  endfunction

  function automatic bit mapped(input logic [7:0] a);
    return a == 8'h00 || a == 8'h04 || a == 8'h08;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit rd, input bit wr, input logic [1:0] d, input logic [7:0] a,
                        input logic [31:0] wd, input string tag);
    logic [31:0] er;
    bit ee;
    er = exp_read(d, a);
    ee = !mapped(a) && (rd || wr);
    @(negedge clk);
    req_rd = rd; req_wr = wr; req_dom = d; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_rd = 1'b0; req_wr = 1'b0;
    if (wr && a == 8'h00) exp_sel[d] = wd;
    check(rsp_valid == rd, {tag, " valid R7"}, 32'(rsp_valid), 32'(rd));
    check(rsp_err == ee, {tag, " err R8"}, 32'(rsp_err), 32'(ee));
    check(rsp_rdata == (rd ? er : 32'h0), {tag, " data"}, rsp_rdata, rd ? er : 32'h0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    for (int d = 0; d < N_DOM; d++) exp_sel[d] = '0;
    for (int i = 0; i < N_AFF; i++) aff_table[i*32 +: 32] = 32'h100 + 32'(i);
    aff_count = 4'd3;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!rsp_valid && !rsp_err && rsp_rdata == 0, "reset outputs R6", rsp_rdata, 0);
    for (int d = 0; d < N_DOM; d++) access(1, 0, 2'(d), 8'h00, 0, "reset selector R6");

    // R1, R2: one domain written, others untouched
    access(0, 1, 2'd2, 8'h00, 32'hDEAD_BEEF, "sel write R1");
    for (int d = 0; d < N_DOM; d++) access(1, 0, 2'(d), 8'h00, 0, "domain isolation R2");
    // R3: config write ignored, reads zero
    access(0, 1, 2'd2, 8'h04, 32'hFFFF_FFFF, "cfg write R3");
    access(1, 0, 2'd2, 8'h04, 0, "cfg read R3");
    access(1, 0, 2'd2, 8'h00, 0, "sel after cfg write R3");
    // R4, R5: status unknown then known
    access(1, 0, 2'd2, 8'h08, 0, "status unknown R4");
    access(0, 1, 2'd1, 8'h00, 32'h102, "sel known");
    access(1, 0, 2'd1, 8'h08, 0, "status known R5");
    // R9: entry beyond count, count 0, count above 8
    access(0, 1, 2'd0, 8'h00, 32'h105, "sel beyond count");
    access(1, 0, 2'd0, 8'h08, 0, "beyond count R9");
    aff_count = 4'd0;
    access(1, 0, 2'd1, 8'h08, 0, "count zero R9");
    aff_count = 4'd15;
    access(0, 1, 2'd3, 8'h00, 32'h107, "sel last entry");
    access(1, 0, 2'd3, 8'h08, 0, "count over max R9");
    // R10: status write ignored
    access(0, 1, 2'd3, 8'h08, 32'h0, "stat write R10");
    access(1, 0, 2'd3, 8'h00, 0, "sel after stat write R10");
    // R8: unmapped
    access(1, 0, 2'd0, 8'h0C, 0, "unmapped read R8");
    access(0, 1, 2'd0, 8'h01, 32'h1234, "unmapped write R8");
    access(1, 0, 2'd0, 8'h00, 0, "sel after unmapped R8");
    // R11: same-cycle read and write
    access(1, 1, 2'd0, 8'h00, 32'hCAFE_0001, "rd+wr old value R11");
    access(1, 0, 2'd0, 8'h00, 0, "rd after rd+wr R11");

    for (int n = 0; n < 600; n++) begin
      logic [1:0]  d = 2'($urandom_range(0, 3));
      logic [7:0]  a;
      logic [31:0] wd;
      int          k = $urandom_range(0, 9);
      if (k < 3)      a = 8'h00;
      else if (k < 5) a = 8'h08;
      else if (k < 7) a = 8'h04;
      else            a = 8'($urandom);
      wd = ($urandom_range(0, 1) == 1) ? aff_table[$urandom_range(0, 7)*32 +: 32] : $urandom;
      if ($urandom_range(0, 19) == 0) aff_count = 4'($urandom);
      if ($urandom_range(0, 39) == 0)
        aff_table[$urandom_range(0, 7)*32 +: 32] = exp_sel[$urandom_range(0, 3)];
      access(1'($urandom), 1'($urandom), d, a, wd, "random R1 R5");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule